// File: doc/BRIEF.md
# Converter Power-Sequencing Frame Generator

This block is the host-side master for a serial converter whose power state is controlled only by how long chip select stays low during a frame. The converter counts falling clock edges. Releasing chip select between the second and tenth falling edge cuts the frame short and moves the part one step deeper into power-down. Holding chip select past the tenth edge makes a complete frame, which either converts or wakes the part.

A request carries one of four commands: convert, enter partial power-down, enter full power-down, or wake. The block keeps its own record of the converter's assumed power state, which is unknown after reset. From that state and the command it builds a plan of up to three frames, each one full or cut short, and each followed by a wait. A wait is either the quiet time or a power-up delay. The power-up delay depends on whether the converter is waking from full or partial power-down and, for partial, on whether its reference is internal or external. The block drives chip select and the serial clock. It pulses `done` once the last wait has elapsed and then updates its state record. Reading the converted data is left to other logic.

The controller has four states. `ST_IDLE` accepts a request and goes to `ST_FRAME`, or straight to `ST_DONE` when the plan is empty. `ST_FRAME` waits for the frame engine to finish and goes to `ST_WAIT`. `ST_WAIT` returns to `ST_FRAME` if frames remain, and otherwise goes to `ST_DONE`. `ST_DONE` emits `done`, commits the new state and goes back to `ST_IDLE`. The frame engine has two states, `F_IDLE` and `F_RUN`.

Top module: `pwrseq_framer`

## Requirements
- R1: After reset, cs_n=1, sclk=1, done=0, req_ready=1 and conv_state=0. The conv_state codes are 0 unknown, 1 normal, 2 partial power-down and 3 full power-down.
- R2: A full frame keeps cs_n low across exactly FRAME_EDGES (16) falling edges of sclk. Successive falls are 2*DIV clock cycles apart, and sclk is high whenever cs_n is high.
- R3: A cut-short frame keeps cs_n low across exactly CUT_EDGE (5) falling edges, and cs_n rises while sclk is low.
- R4: Command 1 (enter partial) issues one cut frame from normal. From unknown it issues a full frame and then a cut frame.
- R5: Command 2 (enter full) issues two cut frames from normal. From unknown it issues a full frame and then two cut frames. From partial it issues one cut frame.
- R6: Command 3 (wake) issues one full frame from unknown, partial or full, and no frame from normal.
- R7: Between the end of any frame and the next cs_n fall, or the done pulse, cs_n stays high for at least QUIET_CYC cycles.
- R8: After a wake frame issued from full power-down or from unknown, at least PWRUP_FULL_CYC cycles pass before the next frame or done.
- R9: A wake from partial power-down waits at least PWRUP_PART_CYC cycles when ref_ext=0. When ref_ext=1 it waits only the quiet time, which is less than PWRUP_PART_CYC.
- R10: Command 0 (convert) issues one full frame from normal. From any other state it issues a wake frame, then the power-up wait, then a second full frame.
- R11: done is a one-cycle pulse. req_ready is low whenever cs_n is low. conv_state changes only in the cycle after done, and takes the command's target state (1 after convert or wake, 2 after partial, 3 after full).
- R12: A command whose target state is already the assumed state (partial from partial, full from full) issues no frame and still pulses done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_cmd | input | 2 | 0 convert, 1 partial, 2 full, 3 wake |
| ref_ext | input | 1 | 1 when the converter uses an external reference |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock, idles high |
| done | output | 1 | One-cycle pulse when a request completes |
| conv_state | output | 2 | Assumed converter power state |

## Verification
A wrong assumed state shows up in the next request, and only there. If the state record is wrong, the number of frames or the mix of full and cut frames differs from the table in R4 to R6 and R10, so each command is issued from every starting state and the frames are counted at the pins. A wrong frame-engine count shows within one frame as a wrong number of sclk falls before cs_n rises. A wrong wait selection shows as a gap or done latency below the required bound, or as an external-reference wake that takes too long, by the end of that same request.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        CMD_CONVERT = 2'd0,
        CMD_PARTIAL = 2'd1,
        CMD_FULL    = 2'd2,
        CMD_WAKE    = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        CS_UNKNOWN = 2'd0,
        CS_NORMAL  = 2'd1,
        CS_PARTIAL = 2'd2,
        CS_FULLPD  = 2'd3
    } conv_state_e;

    typedef enum logic [1:0] {
        WT_QUIET = 2'd0,
        WT_PART  = 2'd1,
        WT_FULL  = 2'd2
    } wait_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } top_st_e;

    localparam int STEP_SLOTS = 4;

    typedef struct packed {
        logic  cut;
        wait_e wt;
    } step_t;

    typedef struct packed {
        logic [1:0]                 n;
        step_t [STEP_SLOTS-1:0]     s;
        conv_state_e                next;
    } plan_t;

    function automatic wait_e wake_wait(conv_state_e st, logic ref_ext);
        if (st == CS_PARTIAL) return ref_ext ? WT_QUIET : WT_PART;
        return WT_FULL;
    endfunction

    function automatic plan_t make_plan(cmd_e c, conv_state_e st, logic ref_ext);
        plan_t p;
        step_t full_q, cut_q, wake_s;
        full_q = '{cut: 1'b0, wt: WT_QUIET};
        cut_q  = '{cut: 1'b1, wt: WT_QUIET};
        wake_s = '{cut: 1'b0, wt: wake_wait(st, ref_ext)};
        p.n    = 2'd0;
        p.s    = '{default: full_q};
        p.next = st;
        unique case (c)
            CMD_CONVERT: begin
                p.next = CS_NORMAL;
                if (st == CS_NORMAL) begin
                    p.n = 2'd1; p.s[0] = full_q;
                end else begin
                    p.n = 2'd2; p.s[0] = wake_s; p.s[1] = full_q;
                end
            end
            CMD_PARTIAL: begin
                p.next = CS_PARTIAL;
                unique case (st)
                    CS_NORMAL:  begin p.n = 2'd1; p.s[0] = cut_q; end
                    CS_UNKNOWN: begin p.n = 2'd2; p.s[0] = full_q; p.s[1] = cut_q; end
                    CS_PARTIAL: p.n = 2'd0;
                    CS_FULLPD:  begin p.n = 2'd2; p.s[0] = wake_s; p.s[1] = cut_q; end
                    default:    p.n = 2'd0;
                endcase
            end
            CMD_FULL: begin
                p.next = CS_FULLPD;
                unique case (st)
                    CS_NORMAL:  begin p.n = 2'd2; p.s[0] = cut_q; p.s[1] = cut_q; end
                    CS_UNKNOWN: begin
                        p.n = 2'd3; p.s[0] = full_q; p.s[1] = cut_q; p.s[2] = cut_q;
                    end
                    CS_PARTIAL: begin p.n = 2'd1; p.s[0] = cut_q; end
                    CS_FULLPD:  p.n = 2'd0;
                    default:    p.n = 2'd0;
                endcase
            end
            CMD_WAKE: begin
                p.next = CS_NORMAL;
                if (st == CS_NORMAL) p.n = 2'd0;
                else begin p.n = 2'd1; p.s[0] = wake_s; end
            end
            default: p.n = 2'd0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pwrseq_frame_unit.sv
module pwrseq_frame_unit #(
    parameter int DIV         = 4,
    parameter int FRAME_EDGES = 16,
    parameter int CUT_EDGE    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic cut,
    output logic cs_n,
    output logic sclk,
    output logic fin
);
    localparam int HW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int EW = $clog2(FRAME_EDGES + 1);
    localparam logic [HW-1:0] HLAST = HW'(DIV - 1);
    localparam logic [EW-1:0] ELAST = EW'(FRAME_EDGES);
    localparam logic [EW-1:0] ECUT  = EW'(CUT_EDGE);

    typedef enum logic {F_IDLE = 1'b0, F_RUN = 1'b1} f_st_e;

    f_st_e          st;
    logic [HW-1:0]  hcnt;
    logic [EW-1:0]  falls;
    logic           cut_q;
    logic           half_end;

    assign half_end = (hcnt == HLAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= F_IDLE;
            hcnt  <= '0;
            falls <= '0;
            cut_q <= 1'b0;
            cs_n  <= 1'b1;
            sclk  <= 1'b1;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            unique case (st)
                F_IDLE: begin
                    if (go) begin
                        st    <= F_RUN;
                        cs_n  <= 1'b0;
                        sclk  <= 1'b1;
                        hcnt  <= '0;
                        falls <= '0;
                        cut_q <= cut;
                    end
                end
                F_RUN: begin
                    if (!half_end) begin
                        hcnt <= hcnt + 1'b1;
                    end else begin
                        hcnt <= '0;
                        if (sclk) begin
                            if (falls == ELAST) begin
                                cs_n <= 1'b1;
                                fin  <= 1'b1;
                                st   <= F_IDLE;
                            end else begin
                                sclk  <= 1'b0;
                                falls <= falls + 1'b1;
                            end
                        end else if (cut_q && falls == ECUT) begin
                            cs_n <= 1'b1;
                            sclk <= 1'b1;
                            fin  <= 1'b1;
                            st   <= F_IDLE;
                        end else begin
                            sclk <= 1'b1;
                        end
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pwrseq_wait_timer.sv
module pwrseq_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] val,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (load) begin
                cnt <= val;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) expire <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwrseq_framer.sv
module pwrseq_framer
    import pwrseq_pkg::*;
#(
    parameter int DIV            = 4,
    parameter int FRAME_EDGES    = 16,
    parameter int CUT_EDGE       = 5,
    parameter int QUIET_CYC      = 16,
    parameter int PWRUP_PART_CYC = 500,
    parameter int PWRUP_FULL_CYC = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [1:0] req_cmd,
    input  logic       ref_ext,
    output logic       cs_n,
    output logic       sclk,
    output logic       done,
    output logic [1:0] conv_state
);
    localparam int PART_EFF = (PWRUP_PART_CYC > QUIET_CYC) ? PWRUP_PART_CYC : QUIET_CYC;
    localparam int FULL_EFF = (PWRUP_FULL_CYC > PART_EFF) ? PWRUP_FULL_CYC : PART_EFF;
    localparam int CW       = $clog2(FULL_EFF + 1);

    top_st_e      st, st_n;
    plan_t        plan_q, plan_d;
    logic [1:0]   idx, idx_nx;
    conv_state_e  conv_state_q;
    logic         frame_go, frame_cut, frame_fin;
    logic         tmr_load, tmr_expire;
    logic [CW-1:0] tmr_val;
    logic         accept, advance;

    function automatic logic [CW-1:0] wait_len(wait_e w);
        unique case (w)
            WT_QUIET: return CW'(QUIET_CYC);
            WT_PART:  return CW'(PART_EFF);
            WT_FULL:  return CW'(FULL_EFF);
            default:  return CW'(FULL_EFF);
        endcase
    endfunction

    assign idx_nx = idx + 2'd1;

    // next-state and control
    always_comb begin
        st_n      = st;
        frame_go  = 1'b0;
        frame_cut = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = wait_len(plan_q.s[idx].wt);
        plan_d    = make_plan(cmd_e'(req_cmd), conv_state_q, ref_ext);
        accept    = 1'b0;
        advance   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (plan_d.n == 2'd0) begin
                        st_n = ST_DONE;
                    end else begin
                        st_n      = ST_FRAME;
                        frame_go  = 1'b1;
                        frame_cut = plan_d.s[0].cut;
                    end
                end
            end
            ST_FRAME: begin
                if (frame_fin) begin
                    st_n     = ST_WAIT;
                    tmr_load = 1'b1;
                end
            end
            ST_WAIT: begin
                if (tmr_expire) begin
                    if (idx_nx < plan_q.n) begin
                        st_n      = ST_FRAME;
                        frame_go  = 1'b1;
                        frame_cut = plan_q.s[idx_nx].cut;
                        advance   = 1'b1;
                    end else begin
                        st_n = ST_DONE;
                    end
                end
            end
            ST_DONE: st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            plan_q       <= '0;
            idx          <= '0;
            conv_state_q <= CS_UNKNOWN;
        end else begin
            st <= st_n;
            if (accept) begin
                plan_q <= plan_d;
                idx    <= '0;
            end
            if (advance) idx <= idx_nx;
            if (st == ST_DONE) conv_state_q <= plan_q.next;
        end
    end

    // outputs
    always_comb begin
        req_ready  = (st == ST_IDLE);
        done       = (st == ST_DONE);
        conv_state = conv_state_q;
    end

    pwrseq_frame_unit #(
        .DIV(DIV), .FRAME_EDGES(FRAME_EDGES), .CUT_EDGE(CUT_EDGE)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .go(frame_go), .cut(frame_cut),
        .cs_n(cs_n), .sclk(sclk), .fin(frame_fin)
    );

    pwrseq_wait_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expire(tmr_expire)
    );
endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker #(
    parameter int FRAME_EDGES = 16,
    parameter int CUT_EDGE    = 5,
    parameter int QUIET_CYC   = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       done,
    input logic       req_ready,
    input logic       frame_go,
    input logic       frame_cut,
    input logic [1:0] conv_state
);
    localparam int EW = $clog2(FRAME_EDGES + 2);
    localparam int QW = $clog2(QUIET_CYC + 2);

    logic          sclk_q, cs_q, cut_q, seen;
    logic [EW-1:0] falls;
    logic [QW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            cs_q   <= 1'b1;
            cut_q  <= 1'b0;
            seen   <= 1'b0;
            falls  <= '0;
            hi_cnt <= '0;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
            if (frame_go) cut_q <= frame_cut;
            if (!cs_n && cs_q) falls <= '0;
            else if (!cs_n && sclk_q && !sclk) falls <= falls + 1'b1;
            if (!cs_n) hi_cnt <= '0;
            else if (hi_cnt != QW'(QUIET_CYC + 1)) hi_cnt <= hi_cnt + 1'b1;
            if (cs_n && !cs_q) seen <= 1'b1;
        end
    end

    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    assert_frame_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_q) |-> (falls == (cut_q ? EW'(CUT_EDGE) : EW'(FRAME_EDGES))));

    assert_quiet_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && cs_q && seen) |-> (hi_cnt >= QW'(QUIET_CYC)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !req_ready);

    assert_state_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(conv_state));
endmodule

bind pwrseq_framer pwrseq_checker #(
    .FRAME_EDGES(FRAME_EDGES), .CUT_EDGE(CUT_EDGE), .QUIET_CYC(QUIET_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .done(done),
    .req_ready(req_ready), .frame_go(frame_go), .frame_cut(frame_cut),
    .conv_state(conv_state)
);

// File: tb/sim_pwrseq_framer.sv
module sim_pwrseq_framer;
    localparam int DIV = 2, FE = 16, CE = 5, QUIET = 6, PPART = 40, PFULL = 200;

    logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, ref_ext = 1'b0;
    logic [1:0] req_cmd = 2'd0;
    logic req_ready, cs_n, sclk, done;
    logic [1:0] conv_state;

    always #4 clk = ~clk;

    pwrseq_framer #(.DIV(DIV), .FRAME_EDGES(FE), .CUT_EDGE(CE), .QUIET_CYC(QUIET),
        .PWRUP_PART_CYC(PPART), .PWRUP_FULL_CYC(PFULL)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .ref_ext(ref_ext), .cs_n(cs_n), .sclk(sclk),
        .done(done), .conv_state(conv_state));

    int errors = 0, checks = 0, cyc = 0;
    int n_fr, cur_edges, rise_cyc, last_fall, done_w, done_lat, per_bad, rdy_bad;
    int edges[4], lowrel[4], gap[4];
    logic prev_cs = 1'b1, prev_sclk = 1'b1;
    bit finished = 0;

    always @(negedge clk) begin
        cyc++;
        if (prev_cs && !cs_n) begin
            if (n_fr < 4) gap[n_fr] = (n_fr > 0) ? cyc - rise_cyc : 0;
            cur_edges = 0; last_fall = -1;
        end
        if (!cs_n && prev_sclk && !sclk) begin
            cur_edges++;
            if (last_fall >= 0 && cyc - last_fall != 2 * DIV) per_bad++;
            last_fall = cyc;
        end
        if (!prev_cs && cs_n) begin
            if (n_fr < 4) begin edges[n_fr] = cur_edges; lowrel[n_fr] = !prev_sclk; end
            n_fr++; rise_cyc = cyc;
        end
        if (!cs_n && req_ready) rdy_bad++;
        if (done) begin
            if (done_w == 0) done_lat = cyc - rise_cyc;
            done_w++;
        end
        prev_cs = cs_n; prev_sclk = sclk;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_ge(string req, int act, int lo);
        checks++;
        if (act < lo) begin
            errors++;
            $display("FAIL %s: actual %0d expected at least %0d", req, act, lo);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic do_reset();
        @(negedge clk); #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic run_cmd(int cmd, bit ext);
        @(negedge clk); #1;
        n_fr = 0; cur_edges = 0; done_w = 0; done_lat = 0; per_bad = 0; rdy_bad = 0;
        for (int i = 0; i < 4; i++) begin edges[i] = 0; lowrel[i] = 0; gap[i] = 0; end
        req_cmd = 2'(cmd); ref_ext = ext; req_valid = 1'b1;
        @(negedge clk); #1 req_valid = 1'b0;
        for (int k = 0; k < 20000 && done_w == 0; k++) @(negedge clk);
        repeat (2) @(negedge clk);
        #1;
        chk("R11 done width", done_w, 1);
        chk("R11 ready while cs low", rdy_bad, 0);
        chk("R2 sclk period", per_bad, 0);
    endtask

    // each scenario task checks its own results
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 1); chk("R1 done", done, 0);
        chk("R1 req_ready", req_ready, 1); chk("R1 conv_state", conv_state, 0);
    endtask

    task automatic t_wake_unknown();
        run_cmd(3, 1'b1);
        chk("R6 frames", n_fr, 1); chk("R2 edges", edges[0], FE);
        chk("R2 release sclk high", lowrel[0], 0);
        chk_ge("R8 wait after unknown wake", done_lat, PFULL);
        chk("R11 state normal", conv_state, 1);
    endtask

    task automatic t_wake_normal();
        run_cmd(3, 1'b1);
        chk("R6 no frame from normal", n_fr, 0); chk("R6 state", conv_state, 1);
    endtask

    task automatic t_convert_normal();
        run_cmd(0, 1'b1);
        chk("R10 frames", n_fr, 1); chk("R10 edges", edges[0], FE);
        chk_ge("R7 quiet before done", done_lat, QUIET);
        chk("R11 state", conv_state, 1);
    endtask

    task automatic t_partial_normal();
        run_cmd(1, 1'b1);
        chk("R4 frames", n_fr, 1); chk("R3 cut edges", edges[0], CE);
        chk("R3 release while sclk low", lowrel[0], 1);
        chk("R11 state partial", conv_state, 2);
    endtask

    task automatic t_partial_again();
        run_cmd(1, 1'b1);
        chk("R12 no frame partial", n_fr, 0); chk("R12 state", conv_state, 2);
    endtask

    task automatic t_wake_partial(bit ext);
        run_cmd(3, ext);
        chk("R6 frames", n_fr, 1); chk("R6 edges", edges[0], FE);
        if (ext) begin
            chk_ge("R9 external quiet", done_lat, QUIET);
            checks++;
            if (done_lat >= PPART) begin
                errors++;
                $display("FAIL R9 external wake too long: actual %0d expected below %0d",
                         done_lat, PPART);
            end
        end else begin
            chk_ge("R9 internal power-up", done_lat, PPART);
        end
        chk("R11 state", conv_state, 1);
    endtask

    task automatic t_full_normal();
        run_cmd(2, 1'b1);
        chk("R5 frames", n_fr, 2); chk("R5 edges0", edges[0], CE); chk("R5 edges1", edges[1], CE);
        chk_ge("R7 gap", gap[1], QUIET);
        chk("R11 state full", conv_state, 3);
    endtask

    task automatic t_full_again();
        run_cmd(2, 1'b1);
        chk("R12 no frame full", n_fr, 0); chk("R12 state", conv_state, 3);
    endtask

    task automatic t_convert_full();
        run_cmd(0, 1'b1);
        chk("R10 frames", n_fr, 2); chk("R10 edges0", edges[0], FE); chk("R10 edges1", edges[1], FE);
        chk_ge("R8 power-up gap", gap[1], PFULL);
        chk("R10 state", conv_state, 1);
    endtask

    task automatic t_full_partial();
        run_cmd(1, 1'b1);
        run_cmd(2, 1'b1);
        chk("R5 frames from partial", n_fr, 1); chk("R5 edges", edges[0], CE);
        chk("R5 state", conv_state, 3);
    endtask

    task automatic t_full_unknown();
        t_reset();
        run_cmd(2, 1'b1);
        chk("R5 frames from unknown", n_fr, 3);
        chk("R5 e0", edges[0], FE); chk("R5 e1", edges[1], CE); chk("R5 e2", edges[2], CE);
        chk_ge("R7 gap1", gap[1], QUIET); chk_ge("R7 gap2", gap[2], QUIET);
        chk("R5 state", conv_state, 3);
    endtask

    task automatic t_partial_unknown();
        t_reset();
        run_cmd(1, 1'b0);
        chk("R4 frames from unknown", n_fr, 2);
        chk("R4 e0", edges[0], FE); chk("R4 e1", edges[1], CE);
        chk("R4 release low", lowrel[1], 1);
        chk("R4 state", conv_state, 2);
    endtask

    initial begin
        t_reset();
        t_wake_unknown();
        t_wake_normal();
        t_convert_normal();
        t_partial_normal();
        t_partial_again();
        t_wake_partial(1'b1);
        t_partial_normal();
        t_wake_partial(1'b0);
        t_full_normal();
        t_full_again();
        t_convert_full();
        t_full_partial();
        t_full_unknown();
        t_partial_unknown();
        finish_run();
    end
endmodule